// File: doc/BRIEF.md
# Block-Confined Word Address Pointer

This block keeps the current word address of a 1024-byte serial memory. The address is 10 bits wide. The memory is split into eight blocks of 128 bytes, and the address is tracked as two parts: a 3-bit block number on top and a 7-bit offset below it. A write command that carries block bits and a word address loads both parts at once. Each completed data byte then moves the offset forward by one. The block number is never touched by that increment, so a long sequential read or a page write stays inside the block that was loaded.

The bus controller that surrounds the block has three jobs. It marks each command with a valid strobe and a read/write flag. It supplies the block bits and word address that come with a write command. It pulses a byte-done strobe after every data byte it transfers. A read command leaves the pointer untouched whatever block bits it carries. A current-address read therefore continues from the stored pointer, inside the block latched by the last write command. The memory array, the bus protocol and the programming timing are handled elsewhere.

Top module: `blk_addr_ptr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cur_addr` becomes 0 at that edge.
- R2: A write command loads the pointer. This is `cmd_valid`=1 with `cmd_is_read`=0. At the next edge `cur_addr` becomes {`cmd_block`, `cmd_word`}, with the block in bits 9:7 and the offset in bits 6:0.
- R3: A `byte_done` pulse with no write command in the same cycle adds one to `cur_addr[6:0]` at the next edge.
- R4: A `byte_done` pulse never changes `cur_addr[9:7]`.
- R5: An offset of 127 wraps to 0 within the same block on `byte_done`, in every block. For example, 127 goes to 0 and 255 goes to 128.
- R6: A read command (`cmd_valid`=1, `cmd_is_read`=1) does not change `cur_addr`, whatever `cmd_block` and `cmd_word` hold. If `byte_done` is high in the same cycle, the increment still happens.
- R7: If a write command and `byte_done` arrive in the same cycle, the load wins and the increment is dropped.
- R8: With no command and no `byte_done`, `cur_addr` holds its value.
- R9: Sixteen `byte_done` pulses after a load step through sixteen consecutive offsets of the loaded block, one per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command header is present this cycle |
| cmd_is_read | input | 1 | 1 = read command, 0 = write command |
| cmd_block | input | 3 | Block bits sent with the command |
| cmd_word | input | 7 | Word address within the block |
| byte_done | input | 1 | One data byte finished this cycle |
| cur_addr | output | 10 | Current word address, registered |

## Verification
Loads are applied at several block and offset values. Increments are run across the end of each of the eight blocks, which separates wrapping inside the block from carrying into the block bits. Read commands are sent with block and word values that differ from the stored pointer, both with and without a byte strobe in the same cycle; this shows whether read-time bits leak into the pointer. A load and a strobe are also applied together, and a 16-byte page run is done, to check the priority rule and the consecutive stepping.

// File: rtl/ptr_pkg.sv
// Package: shared widths and the per-cycle operation code of the address pointer.
// Assumes: the block number is the upper field and the offset the lower field.
package ptr_pkg;
    localparam int unsigned PTR_BLK_W_DEF = 3;
    localparam int unsigned PTR_OFS_W_DEF = 7;

    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_LOAD = 2'd1,
        PTR_STEP = 2'd2
    } ptr_op_e;
endpackage

// File: rtl/ptr_op_decode.sv
// Module: turns the command and byte strobes into one pointer operation.
// Assumes: a load takes priority over a step; read commands never load.
module ptr_op_decode
    import ptr_pkg::*;
(
    input  logic    cmd_valid,
    input  logic    cmd_is_read,
    input  logic    byte_done,
    output ptr_op_e op
);
    // Purpose: choose load, step or hold for this cycle.
    always_comb begin
        if (cmd_valid && !cmd_is_read) begin
            op = PTR_LOAD;
        end else if (byte_done) begin
            op = PTR_STEP;
        end else begin
            op = PTR_HOLD;
        end
    end
endmodule

// File: rtl/ptr_block_reg.sv
// Module: holds the block number; changes only on a load.
// Assumes: synchronous active-low reset to block 0.
module ptr_block_reg
    import ptr_pkg::*;
#(
    parameter int unsigned BLK_W = PTR_BLK_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ptr_op_e          op,
    input  logic [BLK_W-1:0] load_blk,
    output logic [BLK_W-1:0] blk_q
);
    // Purpose: capture the block bits on a load, otherwise keep them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (op == PTR_LOAD) begin
            blk_q <= load_blk;
        end
    end
endmodule

// File: rtl/ptr_offset_ctr.sv
// Module: offset counter within a block; wraps modulo 2**OFS_W with no carry out.
// Assumes: synchronous active-low reset to offset 0.
module ptr_offset_ctr
    import ptr_pkg::*;
#(
    parameter int unsigned OFS_W = PTR_OFS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ptr_op_e          op,
    input  logic [OFS_W-1:0] load_ofs,
    output logic [OFS_W-1:0] ofs_q
);
    localparam logic [OFS_W-1:0] OFS_ONE = OFS_W'(1);

    logic [OFS_W-1:0] ofs_nxt;

    // Purpose: next offset; the add is kept to OFS_W bits so it wraps in place.
    always_comb begin
        unique case (op)
            PTR_LOAD: ofs_nxt = load_ofs;
            PTR_STEP: ofs_nxt = ofs_q + OFS_ONE;
            default:  ofs_nxt = ofs_q;
        endcase
    end

    // Purpose: register the offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else begin
            ofs_q <= ofs_nxt;
        end
    end
endmodule

// File: rtl/blk_addr_ptr.sv
// Module: current word address of a block-partitioned memory.
// A write command loads the block and the offset together. Byte strobes
// advance only the offset, so the address stays inside the loaded block.
// Assumes: strobes are single-cycle and synchronous to clk.
module blk_addr_ptr
    import ptr_pkg::*;
#(
    parameter int unsigned BLK_W = PTR_BLK_W_DEF,
    parameter int unsigned OFS_W = PTR_OFS_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic                   cmd_is_read,
    input  logic [BLK_W-1:0]       cmd_block,
    input  logic [OFS_W-1:0]       cmd_word,
    input  logic                   byte_done,
    output logic [BLK_W+OFS_W-1:0] cur_addr
);
    localparam int unsigned ADDR_W = BLK_W + OFS_W;

    ptr_op_e          op;
    logic [BLK_W-1:0] blk_q;
    logic [OFS_W-1:0] ofs_q;

    ptr_op_decode u_dec (
        .cmd_valid   (cmd_valid),
        .cmd_is_read (cmd_is_read),
        .byte_done   (byte_done),
        .op          (op)
    );

    ptr_block_reg #(.BLK_W(BLK_W)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_blk (cmd_block),
        .blk_q    (blk_q)
    );

    ptr_offset_ctr #(.OFS_W(OFS_W)) u_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_ofs (cmd_word),
        .ofs_q    (ofs_q)
    );

    // Purpose: put the block above the offset to form the address.
    always_comb begin
        cur_addr = ADDR_W'({blk_q, ofs_q});
    end
endmodule

// File: rtl/blk_addr_ptr_chk.sv
// Module: checker for blk_addr_ptr; it only observes the ports.
// Assumes: it is attached through the bind statement at the end of this file.
module blk_addr_ptr_chk #(
    parameter int unsigned BLK_W = 3,
    parameter int unsigned OFS_W = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic                   cmd_is_read,
    input logic [BLK_W-1:0]       cmd_block,
    input logic [OFS_W-1:0]       cmd_word,
    input logic                   byte_done,
    input logic [BLK_W+OFS_W-1:0] cur_addr
);
    localparam int unsigned ADDR_W = BLK_W + OFS_W;

    logic wr_cmd;

    // Purpose: flag a write command in this cycle.
    always_comb wr_cmd = cmd_valid && !cmd_is_read;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cur_addr == '0);

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> cur_addr == ADDR_W'({$past(cmd_block), $past(cmd_word)}));

    // R3
    step_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !wr_cmd) |=>
            cur_addr[OFS_W-1:0] == OFS_W'($past(cur_addr[OFS_W-1:0]) + OFS_W'(1)));

    // R4
    step_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !wr_cmd) |=> $stable(cur_addr[ADDR_W-1:OFS_W]));

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_done && !wr_cmd) |=> $stable(cur_addr));
endmodule

bind blk_addr_ptr blk_addr_ptr_chk #(.BLK_W(BLK_W), .OFS_W(OFS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_is_read (cmd_is_read),
    .cmd_block   (cmd_block),
    .cmd_word    (cmd_word),
    .byte_done   (byte_done),
    .cur_addr    (cur_addr)
);

// File: tb/test_blk_addr_ptr.sv
// Bench: scoreboard for blk_addr_ptr. The driver pushes one expected address per cycle; the monitor pops it after the edge.
module test_blk_addr_ptr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_is_read = 1'b0;
    logic [2:0] cmd_block = '0;
    logic [6:0] cmd_word = '0;
    logic       byte_done = 1'b0;
    logic [9:0] cur_addr;

    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [9:0] model = '0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    blk_addr_ptr i_blk_addr_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_is_read (cmd_is_read),
        .cmd_block   (cmd_block),
        .cmd_word    (cmd_word),
        .byte_done   (byte_done),
        .cur_addr    (cur_addr)
    );

    // Driver: apply one cycle of stimulus and push the expected address for the next edge.
    task automatic drive(input bit rv, input bit v, input bit rd,
                         input logic [2:0] b, input logic [6:0] w,
                         input bit bd, input string tag);
        @(negedge clk);
        rst_n = rv; cmd_valid = v; cmd_is_read = rd;
        cmd_block = b; cmd_word = w; byte_done = bd;
        if (!rv)            model = '0;
        else if (v && !rd)  model = {b, w};
        else if (bd)        model = {model[9:7], 7'(model[6:0] + 7'd1)};
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare 5 ns after each rising edge.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (cur_addr !== e) begin
                errors++;
                $display("FAIL %s: cur_addr=%h expected=%h", t, cur_addr, e);
            end
        end
    end

    initial begin
        // R1: load a non-zero value, then reset clears it
        drive(1, 1, 0, 3'd6, 7'd45, 0, "R2");
        drive(0, 0, 0, 3'd0, 7'd0, 0, "R1");
        drive(0, 1, 0, 3'd5, 7'd9, 1, "R1");
        // R2: loads
        drive(1, 1, 0, 3'd3, 7'h7D, 0, "R2");
        // R3/R5: step across the end of block 3
        drive(1, 0, 0, 3'd0, 7'd0, 1, "R3");
        drive(1, 0, 0, 3'd0, 7'd0, 1, "R3");
        drive(1, 0, 0, 3'd0, 7'd0, 1, "R5");
        drive(1, 0, 0, 3'd0, 7'd0, 1, "R4");
        // R5/R4: wrap in every block
        for (int b = 0; b < 8; b++) begin
            drive(1, 1, 0, 3'(b), 7'd126, 0, "R2");
            drive(1, 0, 0, 3'd0, 7'd0, 1, "R3");
            drive(1, 0, 0, 3'd0, 7'd0, 1, "R5");
            drive(1, 0, 0, 3'd0, 7'd0, 1, "R4");
        end
        // R8: idle holds
        drive(1, 0, 0, 3'd0, 7'd0, 0, "R8");
        drive(1, 0, 1, 3'd2, 7'd5, 0, "R8");
        // R6: read command with other block/word bits is ignored
        drive(1, 1, 0, 3'd1, 7'd20, 0, "R2");
        drive(1, 1, 1, 3'd6, 7'd99, 0, "R6");
        drive(1, 1, 1, 3'd7, 7'd0, 1, "R6");
        drive(1, 0, 0, 3'd0, 7'd0, 1, "R6");
        // R7: load and step together, load wins
        drive(1, 1, 0, 3'd4, 7'd50, 1, "R7");
        drive(1, 1, 0, 3'd2, 7'd127, 1, "R7");
        // R9: 16-byte page run through block 5, ending at the block edge
        drive(1, 1, 0, 3'd5, 7'h70, 0, "R2");
        for (int i = 0; i < 16; i++) drive(1, 0, 0, 3'd0, 7'd0, 1, "R9");
        drive(1, 0, 0, 3'd0, 7'd0, 0, "R8");
        @(negedge clk);
        cmd_valid = 1'b0; byte_done = 1'b0;
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles=200000 expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule